// File: doc/BRIEF.md
# Keyed Configuration Port

This block gives a host a locked, two-address window into a set of byte-wide configuration registers. The host issues byte accesses to one of two addresses. The base address (address bit 0) carries both the index value and the unlock and lock key bytes. The address above it (address bit 1) carries register data. After reset the port is shut. It opens only when the enter key byte is written to the base address in two consecutive base-address writes. While the port is open, a base-address write picks a register and data-port accesses reach that register. Writing the leave key to the base address shuts the port again.

A bank-select register picks one of several logical devices. Each device has an activate bit, and the register window above the activate register is forwarded to an external device bank as one-cycle read and write strobes. The port also holds a read-only identifier register. Requests enter on a valid/ready channel, and read results leave on a second valid/ready channel. `req_ready` is high whenever no read result is waiting or the waiting result is being taken in the same cycle. While a read result waits with `rsp_ready` low, new requests are stalled and the result is held unchanged. Writes produce no response.

Top module: `cfgport_keyed`

## Requirements
- R1: After reset the port is shut, the index is 0x00, the bank select is 0x00, every activate bit is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: The port opens only after the enter key (0x87 by default) is written to address 0 in two consecutive address-0 writes. While the port is not open, any read returns 0xFF and data-port writes change nothing.
- R3: While the port is shut, a write to address 0 of any byte other than the enter key clears the key progress, so a lone enter key that follows it does not open the port.
- R4: While the port is open, writing the leave key (0xAA by default) to address 0 shuts it. After that, data writes are ignored and reads return 0xFF until the port is opened again. The register contents survive the lock.
- R5: When the parameter ALT_KEYS is 1, the enter key is 0x88 and the leave key is 0xBB, and 0x87 does not open the port.
- R6: While the port is open, any address-0 write other than the leave key loads the index, including the byte 0x87. An address-0 read returns the current index.
- R7: Index 0x07 is the bank-select register. It can be read and written, and its value appears on `dev_ldn`.
- R8: Index 0x20 always reads as the CHIP_ID parameter (0x5A by default). Writes to it are ignored.
- R9: Index 0x30 bit 0 is the activate bit of the selected bank. Each bank keeps its own bit, and that bit is shown on `ldn_act[bank]`. A read returns the bit in bit 0 and zeros above it. Banks at or above NUM_LDN read 0.
- R10: Indices 0x31 to 0xFF are forwarded. An accepted data-port write or read raises `dev_wr` or `dev_rd` for that one cycle only, and a forwarded read returns `dev_rdata`. Other unassigned indices below 0x31 read 0x00 and ignore writes.
- R11: `req_ready` is low while `rsp_valid` is high and `rsp_ready` is low. During that time `rsp_rdata` holds its value.
- R12: A read accepted at one clock edge has its result in `rsp_valid` and `rsp_rdata` right after that edge. A write becomes visible to the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 1 | 0 = index/key address, 1 = data address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Host takes the read result |
| rsp_rdata | output | 8 | Read result byte |
| dev_wr | output | 1 | Forwarded register write strobe |
| dev_rd | output | 1 | Forwarded register read strobe |
| dev_ldn | output | 8 | Selected bank number |
| dev_index | output | 8 | Current register index |
| dev_wdata | output | 8 | Forwarded write byte |
| dev_rdata | input | 8 | Read byte from the device bank, same cycle as dev_rd |
| ldn_act | output | NUM_LDN | Activate bit of each bank |

## Verification
A read result is due one register stage after the edge that accepts the read. The bench drives each request on a falling edge, lets one rising edge accept it, and samples `rsp_valid` and `rsp_rdata` on the falling edge that follows. Forwarded strobes are combinational with the accepted request, so the bench model of the device bank captures them on that same accepting edge. Key-state and register changes land on the accepting edge, so every check on them is made through a later access rather than in the same cycle.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_state_e;

  localparam logic [7:0] KEY_ENTER_STD = 8'h87;
  localparam logic [7:0] KEY_LEAVE_STD = 8'hAA;
  localparam logic [7:0] KEY_ENTER_ALT = 8'h88;
  localparam logic [7:0] KEY_LEAVE_ALT = 8'hBB;

  localparam logic [7:0] IDX_BANKSEL = 8'h07;
  localparam logic [7:0] IDX_CHIPID  = 8'h20;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] IDX_FWD_LO  = 8'h31;

  localparam logic [7:0] LOCKED_READ = 8'hFF;

endpackage

// File: rtl/cfgport_keylock.sv
module cfgport_keylock
  import cfgport_pkg::*;
#(
  parameter bit ALT_KEYS = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  output logic       is_open,
  output logic       idx_load
);

  logic [7:0] k_enter;
  logic [7:0] k_leave;

  generate
    if (ALT_KEYS) begin : g_alt_keys
      assign k_enter = KEY_ENTER_ALT;
      assign k_leave = KEY_LEAVE_ALT;
    end else begin : g_std_keys
      assign k_enter = KEY_ENTER_STD;
      assign k_leave = KEY_LEAVE_STD;
    end
  endgenerate

  lock_state_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    idx_load = 1'b0;
    if (key_wr) begin
      unique case (st_q)
        LK_SHUT: st_d = (key_byte == k_enter) ? LK_HALF : LK_SHUT;
        LK_HALF: st_d = (key_byte == k_enter) ? LK_OPEN : LK_SHUT;
        LK_OPEN: begin
          if (key_byte == k_leave) st_d = LK_SHUT;
          else                     idx_load = 1'b1;
        end
        default: st_d = LK_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= LK_SHUT;
    else        st_q <= st_d;
  end

  assign is_open = (st_q == LK_OPEN);

  // R2: the open state is only ever entered from the half-keyed state
  p_open_from_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_OPEN && $past(st_q) != LK_OPEN) |-> $past(st_q) == LK_HALF);

  // R3: a non-key byte after the first key drops progress
  p_break_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && st_q == LK_HALF && key_byte != k_enter) |=> st_q == LK_SHUT);

  // R4: leave key shuts an open port
  p_leave_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && st_q == LK_OPEN && key_byte == k_leave) |=> !is_open);

endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
  import cfgport_pkg::*;
#(
  parameter int         NUM_LDN = 16,
  parameter logic [7:0] CHIP_ID = 8'h5A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               is_open,
  input  logic               idx_load,
  input  logic               data_wr,
  input  logic               data_rd,
  input  logic [7:0]         wdata,
  input  logic [7:0]         dev_rdata,
  output logic [7:0]         idx_q,
  output logic [7:0]         ldn_q,
  output logic [NUM_LDN-1:0] ldn_act,
  output logic               dev_wr,
  output logic               dev_rd,
  output logic [7:0]         rd_value
);

  logic wr_ok, rd_ok, fwd_win, act_we, act_sel;
  logic [NUM_LDN-1:0] act_q;
  logic [NUM_LDN-1:0] act_hit;

  assign wr_ok   = data_wr && is_open;
  assign rd_ok   = data_rd && is_open;
  assign fwd_win = (idx_q >= IDX_FWD_LO);
  assign act_we  = wr_ok && (idx_q == IDX_ACT);

  always_ff @(posedge clk) begin
    if (!rst_n)        idx_q <= 8'h00;
    else if (idx_load) idx_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              ldn_q <= 8'h00;
    else if (wr_ok && idx_q == IDX_BANKSEL)  ldn_q <= wdata;
  end

  generate
    for (genvar i = 0; i < NUM_LDN; i++) begin : g_act
      always_ff @(posedge clk) begin
        if (!rst_n)                             act_q[i] <= 1'b0;
        else if (act_we && ldn_q == 8'(i))      act_q[i] <= wdata[0];
      end
      assign act_hit[i] = act_q[i] && (ldn_q == 8'(i));
    end
  endgenerate

  assign act_sel = |act_hit;
  assign ldn_act = act_q;
  assign dev_wr  = wr_ok && fwd_win;
  assign dev_rd  = rd_ok && fwd_win;

  always_comb begin
    if (fwd_win) begin
      rd_value = dev_rdata;
    end else begin
      unique case (idx_q)
        IDX_BANKSEL: rd_value = ldn_q;
        IDX_CHIPID:  rd_value = CHIP_ID;
        IDX_ACT:     rd_value = {7'b0, act_sel};
        default:     rd_value = 8'h00;
      endcase
    end
  end

  // R9: activate bits move only on an open data write to the activate index
  p_act_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_wr && is_open && idx_q == IDX_ACT) |=> $stable(act_q));

  // R7: bank select moves only on an open data write to its index
  p_ldn_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_wr && is_open && idx_q == IDX_BANKSEL) |=> $stable(ldn_q));

endmodule

// File: rtl/cfgport_keyed.sv
module cfgport_keyed
  import cfgport_pkg::*;
#(
  parameter int         NUM_LDN  = 16,
  parameter logic [7:0] CHIP_ID  = 8'h5A,
  parameter bit         ALT_KEYS = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_addr,
  input  logic [7:0]         req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [7:0]         rsp_rdata,
  output logic               dev_wr,
  output logic               dev_rd,
  output logic [7:0]         dev_ldn,
  output logic [7:0]         dev_index,
  output logic [7:0]         dev_wdata,
  input  logic [7:0]         dev_rdata,
  output logic [NUM_LDN-1:0] ldn_act
);

  logic accept, key_wr, data_wr, data_rd, rd_acc;
  logic is_open, idx_load;
  logic [7:0] idx_q, rd_value;
  logic       rsp_valid_q;
  logic [7:0] rsp_rdata_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign key_wr    = accept && req_write && !req_addr;
  assign data_wr   = accept && req_write && req_addr;
  assign data_rd   = accept && !req_write && req_addr;
  assign rd_acc    = accept && !req_write;

  cfgport_keylock #(.ALT_KEYS(ALT_KEYS)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_byte (req_wdata),
    .is_open  (is_open),
    .idx_load (idx_load)
  );

  cfgport_regs #(.NUM_LDN(NUM_LDN), .CHIP_ID(CHIP_ID)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_open   (is_open),
    .idx_load  (idx_load),
    .data_wr   (data_wr),
    .data_rd   (data_rd),
    .wdata     (req_wdata),
    .dev_rdata (dev_rdata),
    .idx_q     (idx_q),
    .ldn_q     (dev_ldn),
    .ldn_act   (ldn_act),
    .dev_wr    (dev_wr),
    .dev_rd    (dev_rd),
    .rd_value  (rd_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= 8'h00;
    end else if (rd_acc) begin
      rsp_valid_q <= 1'b1;
      if (!is_open)      rsp_rdata_q <= LOCKED_READ;
      else if (req_addr) rsp_rdata_q <= rd_value;
      else               rsp_rdata_q <= idx_q;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
  assign dev_index = idx_q;
  assign dev_wdata = req_wdata;

  // R11: a stalled result holds
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R12: accepted read yields a result after the edge
  p_rsp_next_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  // R10: forwarded strobes only when open
  p_fwd_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr || dev_rd) |-> is_open);

  // R2: reads while not open give 0xFF
  p_locked_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && !is_open) |=> rsp_rdata == 8'hFF);

endmodule

// File: tb/test_cfgport_keyed.sv
`timescale 1ns/100ps
module test_cfgport_keyed;

  localparam int NL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_addr = 1'b0;
  logic [7:0] req_wdata = 8'h00;
  logic rsp_ready = 1'b1;

  logic req_ready, rsp_valid, dev_wr, dev_rd;
  logic [7:0] rsp_rdata, dev_ldn, dev_index, dev_wdata, dev_rdata;
  logic [NL-1:0] ldn_act;

  logic req_ready_a, rsp_valid_a, dev_wr_a, dev_rd_a;
  logic [7:0] rsp_rdata_a, dev_ldn_a, dev_index_a, dev_wdata_a;
  logic [NL-1:0] ldn_act_a;

  always #2.5 clk = ~clk;

  assign dev_rdata = dev_index ^ dev_ldn;

  cfgport_keyed i_cfgport_keyed (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_ldn(dev_ldn), .dev_index(dev_index),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .ldn_act(ldn_act)
  );

  cfgport_keyed #(.ALT_KEYS(1'b1)) i_cfgport_keyed_alt (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready_a),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid_a), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata_a),
    .dev_wr(dev_wr_a), .dev_rd(dev_rd_a), .dev_ldn(dev_ldn_a), .dev_index(dev_index_a),
    .dev_wdata(dev_wdata_a), .dev_rdata(8'h00), .ldn_act(ldn_act_a)
  );

  // device bank model
  int n_devwr = 0, n_devrd = 0;
  logic [7:0] cap_idx = 8'h00, cap_ldn = 8'h00, cap_dat = 8'h00;
  always @(posedge clk) begin
    if (dev_wr) begin
      n_devwr = n_devwr + 1; cap_idx = dev_index; cap_ldn = dev_ldn; cap_dat = dev_wdata;
    end
    if (dev_rd) n_devrd = n_devrd + 1;
  end

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic a, input logic [7:0] d,
                     output logic [7:0] r, output logic [7:0] ra);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r  = rsp_rdata;
    ra = rsp_rdata_a;
    if (!w) chk("R12 rsp_valid after read", {31'b0, rsp_valid}, 32'd1);
  endtask

  // vector: {req tag[3:0], write, addr, wdata[7:0], expected read[7:0]}
  localparam int NV = 41;
  localparam logic [21:0] VEC [NV] = '{
    {4'd2,  1'b0, 1'b1, 8'h00, 8'hFF},  // R2 locked data read
    {4'd2,  1'b1, 1'b0, 8'h87, 8'h00},  // R2 first key
    {4'd3,  1'b1, 1'b0, 8'h00, 8'h00},  // R3 break
    {4'd3,  1'b1, 1'b0, 8'h87, 8'h00},  // R3 key again (one only)
    {4'd3,  1'b0, 1'b1, 8'h00, 8'hFF},  // R3 still shut
    {4'd2,  1'b1, 1'b0, 8'h87, 8'h00},  // R2 second key opens
    {4'd6,  1'b0, 1'b0, 8'h00, 8'h00},  // R6 index read
    {4'd8,  1'b1, 1'b0, 8'h20, 8'h00},
    {4'd8,  1'b0, 1'b1, 8'h00, 8'h5A},  // R8 id
    {4'd8,  1'b1, 1'b1, 8'h33, 8'h00},
    {4'd8,  1'b0, 1'b1, 8'h00, 8'h5A},  // R8 write ignored
    {4'd6,  1'b0, 1'b0, 8'h00, 8'h20},  // R6
    {4'd7,  1'b1, 1'b0, 8'h07, 8'h00},
    {4'd7,  1'b1, 1'b1, 8'h08, 8'h00},
    {4'd7,  1'b0, 1'b1, 8'h00, 8'h08},  // R7
    {4'd9,  1'b1, 1'b0, 8'h30, 8'h00},
    {4'd9,  1'b1, 1'b1, 8'h01, 8'h00},
    {4'd9,  1'b0, 1'b1, 8'h00, 8'h01},  // R9 bank 8 active
    {4'd9,  1'b1, 1'b0, 8'h07, 8'h00},
    {4'd9,  1'b1, 1'b1, 8'h03, 8'h00},
    {4'd9,  1'b1, 1'b0, 8'h30, 8'h00},
    {4'd9,  1'b0, 1'b1, 8'h00, 8'h00},  // R9 bank 3 inactive
    {4'd10, 1'b1, 1'b0, 8'h2A, 8'h00},
    {4'd10, 1'b1, 1'b1, 8'h77, 8'h00},
    {4'd10, 1'b0, 1'b1, 8'h00, 8'h00},  // R10 unassigned low index
    {4'd10, 1'b1, 1'b0, 8'hF6, 8'h00},
    {4'd10, 1'b0, 1'b1, 8'h00, 8'hF5},  // R10 forwarded read F6^03
    {4'd10, 1'b1, 1'b1, 8'hC4, 8'h00},  // R10 forwarded write
    {4'd6,  1'b1, 1'b0, 8'h87, 8'h00},
    {4'd6,  1'b0, 1'b0, 8'h00, 8'h87},  // R6 key byte as index
    {4'd4,  1'b1, 1'b0, 8'h30, 8'h00},
    {4'd4,  1'b1, 1'b0, 8'hAA, 8'h00},  // R4 leave
    {4'd4,  1'b1, 1'b1, 8'h01, 8'h00},
    {4'd4,  1'b0, 1'b1, 8'h00, 8'hFF},  // R4 data read shut
    {4'd4,  1'b0, 1'b0, 8'h00, 8'hFF},  // R4 index read shut
    {4'd4,  1'b1, 1'b0, 8'h87, 8'h00},
    {4'd4,  1'b1, 1'b0, 8'h87, 8'h00},
    {4'd4,  1'b0, 1'b0, 8'h00, 8'h30},  // R4 index survived
    {4'd4,  1'b0, 1'b1, 8'h00, 8'h00},  // R4 locked write ignored
    {4'd7,  1'b1, 1'b0, 8'h07, 8'h00},
    {4'd7,  1'b0, 1'b1, 8'h00, 8'h03}   // R7 bank survived lock
  };

  initial begin
    logic [7:0] r, ra;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
    chk("R1 ldn_act", {16'b0, ldn_act}, 32'd0);
    chk("R1 dev_ldn", {24'b0, dev_ldn}, 32'd0);
    chk("R1 dev_index", {24'b0, dev_index}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][17], VEC[i][16], VEC[i][15:8], r, ra);
      if (!VEC[i][17]) chk($sformatf("R%0d vector %0d", VEC[i][21:18], i), {24'b0, r}, {24'b0, VEC[i][7:0]});
    end

    // R9 per-bank activate pins, R10 bank model capture
    chk("R9 ldn_act", {16'b0, ldn_act}, 32'h0000_0100);
    chk("R10 dev write count", n_devwr, 1);
    chk("R10 dev read count", n_devrd, 1);
    chk("R10 captured index", {24'b0, cap_idx}, 32'hF6);
    chk("R10 captured bank", {24'b0, cap_ldn}, 32'h03);
    chk("R10 captured data", {24'b0, cap_dat}, 32'hC4);

    // R5 alternate keys on second instance
    acc(1'b0, 1'b1, 8'h00, r, ra);
    chk("R5 alt shut after 87 keys", {24'b0, ra}, 32'hFF);
    acc(1'b1, 1'b0, 8'hAA, r, ra);
    acc(1'b1, 1'b0, 8'h88, r, ra);
    acc(1'b1, 1'b0, 8'h88, r, ra);
    acc(1'b1, 1'b0, 8'h20, r, ra);
    acc(1'b0, 1'b1, 8'h00, r, ra);
    chk("R5 alt opened by 88 keys", {24'b0, ra}, 32'h5A);
    chk("R5 default not opened by 88", {24'b0, r}, 32'hFF);
    acc(1'b1, 1'b0, 8'hBB, r, ra);
    acc(1'b0, 1'b1, 8'h00, r, ra);
    chk("R5 alt shut by BB", {24'b0, ra}, 32'hFF);

    // R11 back-pressure
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r = rsp_rdata;
    for (int k = 0; k < 3; k++) begin
      chk("R11 req_ready low", {31'b0, req_ready}, 32'd0);
      chk("R11 rsp held", {23'b0, rsp_valid, rsp_rdata}, {23'b0, 1'b1, r});
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 rsp drained", {31'b0, rsp_valid}, 32'd0);
    chk("R11 req_ready back", {31'b0, req_ready}, 32'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule